// File: doc/BRIEF.md
# Fuse-Configurable Two-Level AND-OR Logic Array

This block models a field-programmable two-level logic array for synthesis. There are twelve dedicated inputs and ten bidirectional lines. Every one of these twenty-two variables is offered to the AND plane in both true and inverted form. The AND plane forms forty-two product terms. Thirty-two of them are logic terms, and an OR plane sums them into ten outputs. Each output then passes through a polarity stage that either passes the sum or inverts it. The other ten product terms are direction terms. Direction term n alone decides whether line n drives its pin. The value seen at each pin is fed back into the AND plane, whether the line is driving or not.

The link map is written through a serial chain while a shift enable is high, one bit per clock. A single load strobe then copies the whole chain into the active map in one step. The pins are split into three ports: a data-out vector, an output-enable vector and a pin-value input. The pin resolution and any feedback settle outside the block. All evaluation inside the block is combinational from the active map and these ports.

Top module: `plc_array`

## Requirements
- R1: Reset sets every bit of the active map and of the chain to 1 (link intact). With this map, every product term is 0, `b_oe` is all zero and `b_out` is all zero for any inputs.
- R2: While `cfg_shift` is high, each clock moves the chain one place toward its top bit and puts `cfg_sdi` in bit 0. After 2178 shifts, the first bit sent is at bit 2177. The bit layout is: bit o is the polarity of output o; bit 10+t*10+o is the OR link of logic term t to output o; bit 330+t*44+2*v is the true link and bit 331+t*44+2*v is the inverted link of variable v in term t. Terms 0..31 are logic terms and terms 32..41 are direction terms for lines 0..9. Variables 0..11 are `in_i` and variables 12..21 are `b_in`. While `cfg_shift` is low the chain holds, and the outputs do not change until a load.
- R3: A variable with only its true link intact requires that variable to be 1. With only its inverted link intact, it requires the variable to be 0. With both links intact, the term is forced to 0.
- R4: A variable with both links removed does not affect the term. A term with every link removed is 1.
- R5: The OR sum of an output is 1 when at least one logic term whose OR link to that output is intact is 1. A term with a removed OR link adds nothing.
- R6: A polarity bit of 1 passes the OR sum to `b_out`, and 0 inverts it.
- R7: `b_oe[n]` equals direction term n. When it is 0 the line is only an input.
- R8: `b_in` feeds the AND plane as variables 12..21, both on lines that drive and on lines that float.
- R9: When `cfg_load` and `cfg_shift` are high on the same edge, the active map takes the chain value from before that edge's shift.
- R10: While `cfg_load` is low, the active map keeps its value, whatever the chain does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset to the all-intact map |
| cfg_shift | input | 1 | Shift enable for the configuration chain |
| cfg_sdi | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copies the chain into the active map |
| in_i | input | 12 | Dedicated inputs |
| b_in | input | 10 | Resolved pin value of each bidirectional line |
| b_out | output | 10 | Value each line drives when enabled |
| b_oe | output | 10 | Drive enable of each line |

## Verification
The bench checks a term with both links of one variable intact; a design that treated that pair as don't-care would raise outputs that must stay low. It checks outputs with no live term under inverted polarity; a design that swapped the polarity sense would show the complement on every output. Lines that float and lines that drive are both read back through the AND plane; a design that fed back its own `b_out` instead of the pin value would miss external values on floating lines. Finally, a load that coincides with a shift must capture the chain as it stood before the shift; a design off by one there would leave every link displaced by one position.

// File: rtl/plc_pkg.sv
package plc_pkg;

   function automatic int plc_lit_count(input int n_in, input int n_io);
      return 2 * (n_in + n_io);
   endfunction

   function automatic int plc_cfg_bits(input int n_in, input int n_io, input int n_lt);
      return (n_lt + n_io) * plc_lit_count(n_in, n_io) + n_lt * n_io + n_io;
   endfunction

endpackage

// File: rtl/plc_cfg_chain.sv
module plc_cfg_chain #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         sdi,
   input  logic         load,
   output logic [W-1:0] chain_q,
   output logic [W-1:0] link_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         link_q  <= '1;
      end else begin
         if (shift_en) chain_q <= {chain_q[W-2:0], sdi};
         if (load)     link_q  <= chain_q;
      end
   end

endmodule

// File: rtl/plc_and_plane.sv
module plc_and_plane #(
   parameter int N_VAR  = 22,
   parameter int N_TERM = 42,
   localparam int N_LIT  = 2 * N_VAR,
   localparam int N_BITS = N_TERM * N_LIT
) (
   input  logic [N_VAR-1:0]  vars,
   input  logic [N_BITS-1:0] links,
   output logic [N_TERM-1:0] terms
);

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_LIT-1:0] row;
      logic             hit;
      assign row = links[t*N_LIT +: N_LIT];
      always_comb begin
         hit = 1'b1;
         for (int v = 0; v < N_VAR; v++) begin
            if (row[2*v]   && !vars[v]) hit = 1'b0;
            if (row[2*v+1] &&  vars[v]) hit = 1'b0;
         end
      end
      assign terms[t] = hit;
   end

endmodule

// File: rtl/plc_or_plane.sv
module plc_or_plane #(
   parameter int N_LT = 32,
   parameter int N_IO = 10,
   localparam int N_BITS = N_LT * N_IO
) (
   input  logic [N_LT-1:0]   terms,
   input  logic [N_BITS-1:0] or_links,
   input  logic [N_IO-1:0]   pol,
   output logic [N_IO-1:0]   dout
);

   for (genvar o = 0; o < N_IO; o++) begin : g_out
      logic [N_LT-1:0] col;
      for (genvar t = 0; t < N_LT; t++) begin : g_col
         assign col[t] = or_links[t*N_IO + o];
      end
      assign dout[o] = pol[o] ? |(terms & col) : ~|(terms & col);
   end

endmodule

// File: rtl/plc_array.sv
module plc_array
   import plc_pkg::*;
#(
   parameter int N_IN = 12,
   parameter int N_IO = 10,
   parameter int N_LT = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_shift,
   input  logic            cfg_sdi,
   input  logic            cfg_load,
   input  logic [N_IN-1:0] in_i,
   input  logic [N_IO-1:0] b_in,
   output logic [N_IO-1:0] b_out,
   output logic [N_IO-1:0] b_oe
);

   localparam int N_VAR    = N_IN + N_IO;
   localparam int N_TERM   = N_LT + N_IO;
   localparam int N_LIT    = plc_lit_count(N_IN, N_IO);
   localparam int AND_BITS = N_TERM * N_LIT;
   localparam int OR_BITS  = N_LT * N_IO;
   localparam int CFG_BITS = plc_cfg_bits(N_IN, N_IO, N_LT);

   if (N_IN < 1) begin : g_bad_in
      $error("plc_array: N_IN must be at least 1");
   end
   if (N_IO < 1) begin : g_bad_io
      $error("plc_array: N_IO must be at least 1");
   end
   if (N_LT < 1) begin : g_bad_lt
      $error("plc_array: N_LT must be at least 1");
   end
   if (CFG_BITS != AND_BITS + OR_BITS + N_IO) begin : g_bad_cfg
      $error("plc_array: configuration length mismatch");
   end

   logic [CFG_BITS-1:0] cfg_chain_q;
   logic [CFG_BITS-1:0] link_q;
   logic [N_TERM-1:0]   terms;

   plc_cfg_chain #(.W(CFG_BITS)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (cfg_shift),
      .sdi      (cfg_sdi),
      .load     (cfg_load),
      .chain_q  (cfg_chain_q),
      .link_q   (link_q)
   );

   plc_and_plane #(.N_VAR(N_VAR), .N_TERM(N_TERM)) u_and (
      .vars  ({b_in, in_i}),
      .links (link_q[N_IO+OR_BITS +: AND_BITS]),
      .terms (terms)
   );

   plc_or_plane #(.N_LT(N_LT), .N_IO(N_IO)) u_or (
      .terms    (terms[N_LT-1:0]),
      .or_links (link_q[N_IO +: OR_BITS]),
      .pol      (link_q[N_IO-1:0]),
      .dout     (b_out)
   );

   assign b_oe = terms[N_TERM-1:N_LT];

endmodule

// File: rtl/plc_array_chk.sv
module plc_array_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cfg_shift,
   input logic         cfg_sdi,
   input logic         cfg_load,
   input logic [W-1:0] chain,
   input logic [W-1:0] links
);

   AST_RESET_MAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&links && &chain)); // R1

   AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_shift |=> chain[0] == $past(cfg_sdi)); // R2

   AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_shift |=> chain[W-1:1] == $past(chain[W-2:0])); // R2

   AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_shift |=> $stable(chain)); // R2

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_load |=> links == $past(chain)); // R9

   AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_load |=> $stable(links)); // R10

endmodule

bind plc_array plc_array_chk #(.W(CFG_BITS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_shift (cfg_shift),
   .cfg_sdi   (cfg_sdi),
   .cfg_load  (cfg_load),
   .chain     (cfg_chain_q),
   .links     (link_q)
);

// File: tb/test_plc_array.sv
`timescale 1ns/1ps
module test_plc_array;

   localparam int N_IN  = 12;
   localparam int N_IO  = 10;
   localparam int N_LT  = 32;
   localparam int N_VAR = N_IN + N_IO;
   localparam int N_TERM = N_LT + N_IO;
   localparam int N_LIT = 2 * N_VAR;
   localparam int OR_B  = N_LT * N_IO;
   localparam int AND_B0 = N_IO + OR_B;
   localparam int W     = AND_B0 + N_TERM * N_LIT;

   localparam int C_OFF = 0, C_H = 1, C_L = 2, C_DC = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_shift = 1'b0, cfg_sdi = 1'b0, cfg_load = 1'b0;
   logic [N_IN-1:0] in_i = '0;
   logic [N_IO-1:0] b_in = '0;
   logic [N_IO-1:0] b_out, b_oe;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [W-1:0] cfg_ref;
   logic [W-1:0] cfg_a, cfg_b;

   logic [3*N_IO-1:0] exp_q[$];
   string             tag_q[$];
   event              ev_chk;

   always #5 clk = ~clk;

   plc_array i_plc_array (
      .clk(clk), .rst_n(rst_n), .cfg_shift(cfg_shift), .cfg_sdi(cfg_sdi),
      .cfg_load(cfg_load), .in_i(in_i), .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
   );

   // configuration builders
   task automatic set_lit(inout logic [W-1:0] c, input int t, input int v, input int code);
      c[AND_B0 + t*N_LIT + 2*v]     = (code == C_OFF || code == C_H);
      c[AND_B0 + t*N_LIT + 2*v + 1] = (code == C_OFF || code == C_L);
   endtask

   task automatic term_dc(inout logic [W-1:0] c, input int t);
      for (int v = 0; v < N_VAR; v++) set_lit(c, t, v, C_DC);
   endtask

   task automatic or_row(inout logic [W-1:0] c, input int t, input logic [N_IO-1:0] mask);
      for (int o = 0; o < N_IO; o++) c[N_IO + t*N_IO + o] = mask[o];
   endtask

   // independent reference with iterative pin resolution
   function automatic void ref_eval(input logic [N_IN-1:0] iv, input logic [N_IO-1:0] ext,
                                    output logic [N_IO-1:0] o, output logic [N_IO-1:0] oe,
                                    output logic [N_IO-1:0] pin);
      logic [N_VAR-1:0]  vars;
      logic [N_TERM-1:0] tm;
      logic              s;
      pin = ext; o = '0; oe = '0;
      for (int k = 0; k < N_IO + 2; k++) begin
         vars = {pin, iv};
         for (int t = 0; t < N_TERM; t++) begin
            tm[t] = 1'b1;
            for (int v = 0; v < N_VAR; v++) begin
               if (cfg_ref[AND_B0 + t*N_LIT + 2*v]     && !vars[v]) tm[t] = 1'b0;
               if (cfg_ref[AND_B0 + t*N_LIT + 2*v + 1] &&  vars[v]) tm[t] = 1'b0;
            end
         end
         for (int q = 0; q < N_IO; q++) begin
            s = 1'b0;
            for (int t = 0; t < N_LT; t++)
               if (tm[t] && cfg_ref[N_IO + t*N_IO + q]) s = 1'b1;
            o[q]  = cfg_ref[q] ? s : ~s;
            oe[q] = tm[N_LT + q];
         end
         pin = (oe & o) | (~oe & ext);
      end
   endfunction

   // driver: apply a vector, settle pins, push expectation
   task automatic apply_vec(input string tag, input logic [N_IN-1:0] iv, input logic [N_IO-1:0] ext);
      logic [N_IO-1:0] eo, eoe, ep;
      in_i = iv;
      for (int k = 0; k < N_IO + 2; k++) begin
         #1;
         b_in = (b_oe & b_out) | (~b_oe & ext);
      end
      #1;
      ref_eval(iv, ext, eo, eoe, ep);
      exp_q.push_back({eo, eoe, ep});
      tag_q.push_back(tag);
      -> ev_chk;
      #1;
   endtask

   // monitor: pop and compare
   initial begin
      forever begin
         @(ev_chk);
         begin
            logic [3*N_IO-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({b_out, b_oe, b_in} !== e) begin
               errors++;
               $display("FAIL %s out/oe/pin=%h/%h/%h expected %h/%h/%h", t,
                        b_out, b_oe, b_in, e[3*N_IO-1:2*N_IO], e[2*N_IO-1:N_IO], e[N_IO-1:0]);
            end
         end
      end
   end

   task automatic shift_cfg(input logic [W-1:0] c);
      @(negedge clk);
      cfg_shift = 1'b1;
      for (int i = W-1; i >= 0; i--) begin
         cfg_sdi = c[i];
         @(negedge clk);
      end
      cfg_shift = 1'b0;
   endtask

   task automatic pulse_load();
      @(negedge clk);
      cfg_load = 1'b1;
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic rand_vecs(input string tag, input int n);
      for (int i = 0; i < n; i++)
         apply_vec(tag, N_IN'($urandom), N_IO'($urandom));
   endtask

   initial begin
      // config A
      cfg_a = '1;
      term_dc(cfg_a, 0); set_lit(cfg_a, 0, 0, C_H); set_lit(cfg_a, 0, 1, C_L);
      or_row(cfg_a, 0, 10'b10_0000_0001);
      term_dc(cfg_a, 1); or_row(cfg_a, 1, 10'b00_0000_0110);
      term_dc(cfg_a, 2); set_lit(cfg_a, 2, 2, C_H); set_lit(cfg_a, 2, 3, C_H);
      or_row(cfg_a, 2, 10'b00_0000_1000);
      term_dc(cfg_a, 3); set_lit(cfg_a, 3, 4, C_L); or_row(cfg_a, 3, 10'b00_0000_1000);
      term_dc(cfg_a, 4); set_lit(cfg_a, 4, 5, C_H); set_lit(cfg_a, 4, 6, C_OFF);
      or_row(cfg_a, 4, 10'b00_0010_0000);
      term_dc(cfg_a, 5); set_lit(cfg_a, 5, 12, C_H); or_row(cfg_a, 5, 10'b10_0100_0000);
      term_dc(cfg_a, 6); set_lit(cfg_a, 6, 17, C_H); or_row(cfg_a, 6, 10'b00_1000_0000);
      term_dc(cfg_a, 7); set_lit(cfg_a, 7, 13, C_L); set_lit(cfg_a, 7, 10, C_H);
      or_row(cfg_a, 7, 10'b01_0000_0000);
      cfg_a[2] = 1'b0; cfg_a[3] = 1'b0; cfg_a[4] = 1'b0; cfg_a[9] = 1'b0;
      term_dc(cfg_a, N_LT + 0);
      term_dc(cfg_a, N_LT + 1); set_lit(cfg_a, N_LT + 1, 7, C_H);
      term_dc(cfg_a, N_LT + 3); set_lit(cfg_a, N_LT + 3, 8, C_H); set_lit(cfg_a, N_LT + 3, 9, C_L);
      term_dc(cfg_a, N_LT + 8); set_lit(cfg_a, N_LT + 8, 18, C_H);
      // config B: polarity flipped, line 5 drives
      cfg_b = cfg_a ^ {{(W-N_IO){1'b0}}, {N_IO{1'b1}}};
      term_dc(cfg_b, N_LT + 5);

      cfg_ref = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      rand_vecs("R1 unprogrammed", 4);
      apply_vec("R1 all ones", '1, '1);

      shift_cfg(cfg_a);
      rand_vecs("R2 shifted but not loaded", 3);
      pulse_load();
      cfg_ref = cfg_a;

      apply_vec("R3 true/inverted literal", 12'h001, '0);
      apply_vec("R3 literal mismatch", 12'h003, '0);
      apply_vec("R3 paired intact links", 12'h060, '0);
      apply_vec("R4 don't-care term", 12'h000, '0);
      apply_vec("R5 sum of two terms", 12'h00C, '0);
      apply_vec("R5 sum second term", 12'h010, '0);
      apply_vec("R6 inverted sum", 12'h01C, '1);
      apply_vec("R7 enable by I7", 12'h080, '0);
      apply_vec("R7 enable by I8 and not I9", 12'h100, '0);
      apply_vec("R8 driven line feedback", 12'h001, '0);
      apply_vec("R8 floating line feedback", 12'h000, 10'h060);
      apply_vec("R8 driven line 1 feedback", 12'h480, 10'h002);
      rand_vecs("R5 random", 30);

      // R10: chain activity without load leaves the map alone
      @(negedge clk);
      cfg_shift = 1'b1;
      for (int i = 0; i < 40; i++) begin
         cfg_sdi = i[0];
         @(negedge clk);
      end
      cfg_shift = 1'b0;
      rand_vecs("R10 map held", 5);

      // R9: load on the same edge as a shift
      shift_cfg(cfg_b);
      cfg_shift = 1'b1; cfg_load = 1'b1; cfg_sdi = ~cfg_b[W-1];
      @(negedge clk);
      cfg_shift = 1'b0; cfg_load = 1'b0;
      cfg_ref = cfg_b;
      apply_vec("R9 load with shift", 12'h000, '0);
      apply_vec("R6 polarity flipped", 12'h001, '0);
      apply_vec("R8 line 5 drives feedback", 12'h020, '0);
      rand_vecs("R9 random", 20);

      // R1: reset again
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      cfg_ref = '1;
      rand_vecs("R1 after second reset", 4);

      #5;
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule